// File: doc/BRIEF.md
# Smart Card Serial Status Flags

This block holds the status flags of a serial port working in smart card mode. It keeps three flags: parity error, receive full and transmit end. It also decides whether the receiver may take the next character. Received characters arrive over a valid/ready handshake. The block raises `rx_ready` only while reception is enabled and no parity error is pending. A character is accepted on a cycle where both `rx_valid` and `rx_ready` are high. While `rx_ready` is low the sender must hold its character, and nothing is stored.

Every accepted character is stored in the holding register. A character with good parity also raises the receive-full flag. A character with bad parity raises the parity-error flag instead, and this blocks all further reception until software clears the flag.

The transmit-end flag is timed in half-etu ticks from a start-of-transmission pulse. The delay depends on the guard and block mode bits. A flag cleared by software needs a status read that sees it at 1, followed by a write of 0 to its bit.

Top module: `sc_status_flags`

## Requirements
- R1: After reset, the parity-error flag is 0, the transmit-end flag is 1, the receive-full flag is 0 and the holding register is 0.
- R2: `rx_ready` is high exactly when reception is enabled and the parity-error flag is 0. Each accepted character is loaded into `rx_hold`.
- R3: An accepted character with good parity sets the receive-full flag and leaves the parity-error flag unchanged.
- R4: An accepted character with a parity error sets the parity-error flag and is stored, but it does not set the receive-full flag.
- R5: While the parity-error flag is 1, offered characters are not accepted: `rx_hold` and the receive-full flag keep their values.
- R6: The parity-error flag clears only on a status write with `stat_wdata[1]`=0 that follows a status read which saw the flag at 1. Such a write without that read does nothing, and disabling reception does not change the flag.
- R7: After `tx_start`, the transmit-end flag sets on the clock edge of a given half-etu tick, counted from the start. That tick is the 25th when guard=0 and block=0, the 23rd when guard=0 and block=1, and the 22nd when guard=1, whatever the block bit. The mode is sampled at `tx_start`.
- R8: When the interval ends, the flag sets only if `err_sig` is 0 and `tdr_empty` is 1.
- R9: Whenever `tx_en` is 0 and `err_sig` is 0, the transmit-end flag is set on the next edge.
- R10: The transmit-end flag clears on `dma_tdr_wr`, or on a status write with `stat_wdata[2]`=0 that follows a status read which saw `tdr_empty` at 1. Such a write without that read does nothing.
- R11: When a set condition and a clear condition for a flag arrive in the same cycle, the flag ends up set.
- R12: The receive-full flag clears on a status write with `stat_wdata[0]`=0 that follows a status read which saw the flag at 1. Such a write without that read does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_etu_tick | input | 1 | One pulse per half elementary time unit |
| tx_start | input | 1 | Pulse at the start of a character transmission |
| guard_mode | input | 1 | Guard mode bit |
| block_mode | input | 1 | Block transfer mode bit |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| err_sig | input | 1 | Error signal returned by the receiving side |
| tdr_empty | input | 1 | Transmit data register empty status |
| rx_valid | input | 1 | Received character offered |
| rx_ready | output | 1 | Receiver can take a character |
| rx_par_err | input | 1 | Parity result of the offered character (1 = bad) |
| rx_data | input | DATA_W | Offered character |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 3 | Write data: bit0 receive full, bit1 parity error, bit2 transmit data empty |
| dma_tdr_wr | input | 1 | DMA write into the transmit data register |
| par_err_flag | output | 1 | Parity-error flag |
| tx_end_flag | output | 1 | Transmit-end flag |
| rx_full_flag | output | 1 | Receive-full flag |
| rx_hold | output | DATA_W | Holding register for the last accepted character |

## Verification
The bench uses the default parameters: 8-bit characters and thresholds of 25, 23 and 22 half ticks, which gives a 5-bit counter. With these values, each mode's threshold, and the tick just before it, is reached within a few dozen cycles. That lets the vector table probe every edge of the transmit-end timing. It also leaves room for directed tests of the handshake, the clearing rules and the same-cycle set-versus-clear cases.

// File: rtl/sc_flags_pkg.sv
package sc_flags_pkg;
  typedef enum logic [1:0] {
    TXM_PLAIN = 2'd0,
    TXM_BLOCK = 2'd1,
    TXM_GUARD = 2'd2
  } tx_mode_e;

  function automatic tx_mode_e mode_of(input logic guard, input logic blk);
    if (guard) return TXM_GUARD;
    else if (blk) return TXM_BLOCK;
    else return TXM_PLAIN;
  endfunction

  typedef struct packed {
    logic tdre;
    logic per;
    logic rdrf;
  } wbits_t;
endpackage

// File: rtl/sc_tend_timer.sv
module sc_tend_timer
  import sc_flags_pkg::*;
#(
  parameter int TH_PLAIN = 25,
  parameter int TH_BLOCK = 23,
  parameter int TH_GUARD = 22,
  parameter int CW       = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     tick,
  input  tx_mode_e mode,
  output logic     expire
);
  localparam logic [CW-1:0] LIM_P = CW'(TH_PLAIN - 1);
  localparam logic [CW-1:0] LIM_B = CW'(TH_BLOCK - 1);
  localparam logic [CW-1:0] LIM_G = CW'(TH_GUARD - 1);

  logic [CW-1:0] cnt;
  logic          running;
  tx_mode_e      mode_q;
  logic [CW-1:0] lim;

  always_comb begin
    unique case (mode_q)
      TXM_BLOCK: lim = LIM_B;
      TXM_GUARD: lim = LIM_G;
      default:   lim = LIM_P;
    endcase
  end

  assign expire = running && tick && !start && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      mode_q  <= TXM_PLAIN;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
      mode_q  <= mode;
    end else if (running && tick) begin
      cnt <= cnt + 1'b1;
      if (cnt == lim) running <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_clear_arm.sv
module sc_clear_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic rd_stb,
  input  logic consume,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n)              armed <= 1'b0;
    else if (consume || !flag) armed <= 1'b0;
    else if (rd_stb)         armed <= 1'b1;
  end
endmodule

// File: rtl/sc_status_flags.sv
module sc_status_flags
  import sc_flags_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TH_PLAIN = 25,
  parameter int TH_BLOCK = 23,
  parameter int TH_GUARD = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_etu_tick,
  input  logic              tx_start,
  input  logic              guard_mode,
  input  logic              block_mode,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              err_sig,
  input  logic              tdr_empty,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_par_err,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [2:0]        stat_wdata,
  input  logic              dma_tdr_wr,
  output logic              par_err_flag,
  output logic              tx_end_flag,
  output logic              rx_full_flag,
  output logic [DATA_W-1:0] rx_hold
);
  localparam int TH_MAX0 = (TH_PLAIN > TH_BLOCK) ? TH_PLAIN : TH_BLOCK;
  localparam int TH_MAX  = (TH_MAX0 > TH_GUARD) ? TH_MAX0 : TH_GUARD;
  localparam int CW      = $clog2(TH_MAX + 1);
  localparam int NFLAG   = 3;

  wbits_t wb;
  assign wb = wbits_t'(stat_wdata);

  logic expire;
  sc_tend_timer #(
    .TH_PLAIN(TH_PLAIN), .TH_BLOCK(TH_BLOCK), .TH_GUARD(TH_GUARD), .CW(CW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .tick(half_etu_tick),
    .mode(mode_of(guard_mode, block_mode)), .expire(expire)
  );

  // arm index 0: receive full, 1: parity error, 2: transmit data empty
  logic [NFLAG-1:0] arm_src, arm_zero, armed;
  assign arm_src  = {tdr_empty, par_err_flag, rx_full_flag};
  assign arm_zero = {stat_wr && !wb.tdre, stat_wr && !wb.per, stat_wr && !wb.rdrf};

  for (genvar i = 0; i < NFLAG; i++) begin : g_arm
    sc_clear_arm u_arm (
      .clk(clk), .rst_n(rst_n), .flag(arm_src[i]), .rd_stb(stat_rd),
      .consume(arm_zero[i]), .armed(armed[i])
    );
  end

  logic accept;
  assign rx_ready = rx_en && !par_err_flag;
  assign accept   = rx_valid && rx_ready;

  logic per_set, per_clr, rdrf_set, rdrf_clr, tend_set, tend_clr;
  assign per_set  = accept && rx_par_err;
  assign per_clr  = armed[1] && arm_zero[1];
  assign rdrf_set = accept && !rx_par_err;
  assign rdrf_clr = armed[0] && arm_zero[0];
  assign tend_set = (expire && !err_sig && tdr_empty) || (!tx_en && !err_sig);
  assign tend_clr = dma_tdr_wr || (armed[2] && arm_zero[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_err_flag <= 1'b0;
      rx_full_flag <= 1'b0;
      tx_end_flag  <= 1'b1;
      rx_hold      <= '0;
    end else begin
      if (per_set)       par_err_flag <= 1'b1;
      else if (per_clr)  par_err_flag <= 1'b0;
      if (rdrf_set)      rx_full_flag <= 1'b1;
      else if (rdrf_clr) rx_full_flag <= 1'b0;
      if (tend_set)      tx_end_flag  <= 1'b1;
      else if (tend_clr) tx_end_flag  <= 1'b0;
      if (accept)        rx_hold      <= rx_data;
    end
  end
endmodule

// File: rtl/sc_status_flags_chk.sv
module sc_status_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              rx_en,
  input logic              err_sig,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_par_err,
  input logic [DATA_W-1:0] rx_data,
  input logic              stat_wr,
  input logic [2:0]        stat_wdata,
  input logic              dma_tdr_wr,
  input logic              par_err_flag,
  input logic              tx_end_flag,
  input logic              rx_full_flag,
  input logic [DATA_W-1:0] rx_hold
);
  p_ready_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_flag |-> !rx_ready);

  p_hold_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (rx_hold == $past(rx_data)));

  p_no_full_on_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_par_err && !rx_full_flag) |=> !rx_full_flag);

  p_per_clear_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_err_flag) |-> ($past(stat_wr) && !$past(stat_wdata[1])));

  p_tend_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !err_sig) |=> tx_end_flag);

  p_tend_fall_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_end_flag) |-> ($past(dma_tdr_wr) || ($past(stat_wr) && !$past(stat_wdata[2]))));
endmodule

bind sc_status_flags sc_status_flags_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sc_status_flags_test.sv
module sc_status_flags_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, half_etu_tick, tx_start, guard_mode, block_mode, tx_en, rx_en;
  logic err_sig, tdr_empty, rx_valid, rx_ready, rx_par_err, stat_rd, stat_wr;
  logic [7:0] rx_data, rx_hold;
  logic [2:0] stat_wdata;
  logic dma_tdr_wr, par_err_flag, tx_end_flag, rx_full_flag;

  sc_status_flags uut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic pulse_rd(); stat_rd = 1; cyc(); stat_rd = 0; endtask
  task automatic pulse_wr(input logic [2:0] v);
    stat_wr = 1; stat_wdata = v; cyc(); stat_wr = 0; stat_wdata = 3'b111;
  endtask
  task automatic send_char(input logic [7:0] d, input logic pe);
    rx_valid = 1; rx_data = d; rx_par_err = pe; cyc(); rx_valid = 0; rx_par_err = 0;
  endtask
  task automatic dma_pulse(); dma_tdr_wr = 1; cyc(); dma_tdr_wr = 0; endtask
  task automatic run_tx(input logic g, input logic b, input int n);
    guard_mode = g; block_mode = b; tx_start = 1; cyc(); tx_start = 0;
    for (int k = 0; k < n; k++) begin
      half_etu_tick = 1; cyc(); half_etu_tick = 0; cyc();
    end
  endtask

  // {guard, block, expected flag, tick count[4:0]}
  localparam logic [7:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 5'd24}, {1'b0, 1'b0, 1'b1, 5'd25},
    {1'b0, 1'b1, 1'b0, 5'd22}, {1'b0, 1'b1, 1'b1, 5'd23},
    {1'b1, 1'b0, 1'b0, 5'd21}, {1'b1, 1'b1, 1'b1, 5'd22},
    {1'b1, 1'b0, 1'b1, 5'd22}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; half_etu_tick = 0; tx_start = 0; guard_mode = 0; block_mode = 0;
    tx_en = 1; rx_en = 1; err_sig = 0; tdr_empty = 1; rx_valid = 0; rx_par_err = 0;
    rx_data = '0; stat_rd = 0; stat_wr = 0; stat_wdata = 3'b111; dma_tdr_wr = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 per", par_err_flag, 0);
    chk("R1 tend", tx_end_flag, 1);
    chk("R1 rdrf", rx_full_flag, 0);
    chk("R1 hold", rx_hold, 0);
    chk("R2 ready", rx_ready, 1);

    // vector table: transmit-end timing per mode (R7)
    for (int i = 0; i < 7; i++) begin
      dma_pulse();
      run_tx(VEC[i][7], VEC[i][6], int'(VEC[i][4:0]));
      chk($sformatf("R7 row %0d", i), tx_end_flag, VEC[i][5]);
    end

    // receive path
    send_char(8'hA5, 0);
    chk("R3 rdrf set", rx_full_flag, 1);
    chk("R2 hold", rx_hold, 8'hA5);
    chk("R3 per unchanged", par_err_flag, 0);
    pulse_wr(3'b000);
    chk("R12 write w/o read", rx_full_flag, 1);
    pulse_rd();
    pulse_wr(3'b110);
    chk("R12 clear", rx_full_flag, 0);

    send_char(8'h3C, 1);
    chk("R4 per set", par_err_flag, 1);
    chk("R4 hold", rx_hold, 8'h3C);
    chk("R4 no rdrf", rx_full_flag, 0);
    chk("R5 ready low", rx_ready, 0);
    send_char(8'h77, 0);
    chk("R5 hold kept", rx_hold, 8'h3C);
    chk("R5 rdrf kept", rx_full_flag, 0);

    pulse_wr(3'b101);
    chk("R6 write w/o read", par_err_flag, 1);
    rx_en = 0; cyc(); cyc();
    chk("R6 rx_en off", par_err_flag, 1);
    rx_en = 1;
    pulse_rd();
    pulse_wr(3'b101);
    chk("R6 clear", par_err_flag, 0);
    chk("R2 ready back", rx_ready, 1);

    send_char(8'h11, 0);
    pulse_rd();
    stat_wr = 1; stat_wdata = 3'b110; rx_valid = 1; rx_data = 8'h22; cyc();
    stat_wr = 0; stat_wdata = 3'b111; rx_valid = 0;
    chk("R11 rdrf set wins", rx_full_flag, 1);
    chk("R11 hold", rx_hold, 8'h22);

    // gating of the timed set
    dma_pulse();
    err_sig = 1;
    run_tx(0, 0, 25);
    chk("R8 err blocks", tx_end_flag, 0);
    err_sig = 0; tdr_empty = 0;
    run_tx(0, 0, 25);
    chk("R8 tdre blocks", tx_end_flag, 0);
    tdr_empty = 1;
    run_tx(0, 0, 25);
    chk("R8 set ok", tx_end_flag, 1);

    // clearing by write
    pulse_wr(3'b011);
    chk("R10 write w/o read", tx_end_flag, 1);
    pulse_rd();
    pulse_wr(3'b011);
    chk("R10 write clear", tx_end_flag, 0);

    // forced set
    tx_en = 0; err_sig = 1; cyc(); cyc();
    chk("R9 err holds off", tx_end_flag, 0);
    err_sig = 0; cyc();
    chk("R9 forced", tx_end_flag, 1);
    dma_pulse();
    chk("R11 tend set wins", tx_end_flag, 1);
    tx_en = 1; cyc();
    dma_pulse();
    chk("R10 dma clear", tx_end_flag, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule